// File: doc/BRIEF.md
# Quad output serial flash reader

This block is a host-side engine that performs a single quad-output read on a four-wire serial flash bus. Software or a neighbouring engine presents a start address, a byte count, an address-width select and a dummy-cycle count, then pulses `start`. The engine lowers chip select and shifts out the one-byte read instruction on lane 0, one bit per serial clock. It then shifts the address out on the same lane, again one bit per serial clock. Next it releases the bus for the programmed number of idle clocks. After that it collects one four-bit nibble per rising serial clock edge from all four lanes and delivers each assembled byte on a valid/ready stream.

The serial clock comes from a divided enable of the system clock. Each half period of the serial clock lasts `CLK_DIV` system clocks. The serial clock idles low. Outgoing bits change on its falling edge and incoming nibbles are sampled on its rising edge. When the consumer does not take a finished byte, the engine stops the serial clock just before it would finish the next byte. No data is dropped. Chip select returns high after the last requested byte. The engine stays busy until chip select has been high for a full serial clock period.

Top module: `qspi_quad_reader`

## Requirements
- R1: An accepted read first shifts out an 8-bit instruction on `io_out[0]`, MSB first, one bit per `sck` rising edge. The instruction is 8'h6B when `addr4` is 0 and 8'h6C when `addr4` is 1.
- R2: The instruction is followed directly by the address, MSB first on `io_out[0]`. The address is `start_addr[23:0]` (24 bits) when `addr4` is 0 and `start_addr[31:0]` (32 bits) when `addr4` is 1.
- R3: `io_oe[0]` is 1 only while the instruction and address are being sent. `io_oe[3:1]` is always 0.
- R4: After the last address bit, exactly `dummy_cycles` rising edges of `sck` pass before data sampling begins, and `io_in` is ignored during them. A value of 0 means data starts on the next rising edge. The total number of rising edges in a read is (32 or 40) + `dummy_cycles` + 2 × `byte_count`.
- R5: Each byte takes two rising edges of `sck`. On the first, `io_in[3:0]` gives byte bits 7..4. On the second, it gives bits 3..0. `io_in` is sampled only at rising edges of `sck`.
- R6: Exactly `byte_count` bytes are delivered, in address order. `cs_n` goes high after the last one. `sck` is low whenever `cs_n` is high.
- R7: Once `m_valid` is 1, it and `m_data` hold until `m_ready` is 1. The serial clock is held rather than losing a byte.
- R8: A `start` pulse is ignored, leaving `busy` low and `cs_n` high, when `quad_en` is 0 or `byte_count` is 0. A `start` pulse during a read has no effect on that read.
- R9: `busy` rises the cycle after an accepted start. It falls only after `cs_n` has been high for at least 2 × `CLK_DIV` system clocks.
- R10: After reset, `cs_n` is 1 and `sck`, `busy`, `m_valid` and `io_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_en | input | 1 | Flash quad mode is known to be enabled; a read is accepted only when 1 |
| start | input | 1 | Request pulse for a read |
| addr4 | input | 1 | 1 selects a 32-bit address, 0 a 24-bit address |
| start_addr | input | 32 | Address of the first byte |
| byte_count | input | LEN_W | Number of bytes to read (0 refused) |
| dummy_cycles | input | DUMMY_W | Idle serial clocks between the address and the data |
| busy | output | 1 | A read or its chip-select recovery is in progress |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| m_valid | output | 1 | Byte stream valid |
| m_data | output | 8 | Byte stream data |
| m_ready | input | 1 | Byte stream ready |

## Verification
The bench sweeps both address widths, dummy counts of 0, 1, 2, 8 and 15, and several byte counts, with start addresses just below the top of the address space. A flash responder in the bench changes its lanes on falling `sck` edges. If the engine sampled on the wrong edge, swapped nibble order or miscounted dummy clocks, every byte would arrive shifted by a nibble. If the engine truncated the 24-bit address wrongly or picked the wrong instruction, the captured instruction and address would not match. Consumers that stall for long stretches test the stream. An engine that kept clocking while its output register was full would drop or overwrite bytes. Refused and overlapping start pulses test that a bad request neither starts nor disturbs a read.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SEND  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_GUARD = 3'd4
  } phase_t;

  localparam logic [7:0] OP_QREAD_A24 = 8'h6B;
  localparam logic [7:0] OP_QREAD_A32 = 8'h6C;
  localparam int         FRAME_W      = 40;

  // Instruction code depends on the address width
  function automatic logic [7:0] read_opcode(input logic wide);
    return wide ? OP_QREAD_A32 : OP_QREAD_A24;
  endfunction

  // Instruction and address packed MSB first, left aligned in the frame
  function automatic logic [FRAME_W-1:0] build_frame(input logic [31:0] addr,
                                                     input logic wide);
    logic [FRAME_W-1:0] f;
    if (wide) f = {read_opcode(1'b1), addr};
    else      f = {read_opcode(1'b0), addr[23:0], 8'h00};
    return f;
  endfunction

  // Number of serial clocks spent on instruction plus address
  function automatic logic [5:0] frame_bits(input logic wide);
    return wide ? 6'd40 : 6'd32;
  endfunction

  // Upper nibble arrives first
  function automatic logic [7:0] join_nibbles(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/qrd_clkdiv.sv
module qrd_clkdiv #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int             DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0]  LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/qrd_txshift.sv
module qrd_txshift
  import qrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] addr,
  input  logic        addr4,
  input  logic        shift,
  output logic        io0
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= build_frame(addr, addr4);
    else if (shift) sr <= {sr[FRAME_W-2:0], 1'b0};
  end

  assign io0 = sr[FRAME_W-1];
endmodule

// File: rtl/qrd_rxpack.sv
module qrd_rxpack
  import qrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic       cap_hi,
  input  logic [3:0] io_in,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       byte_done,
  output logic       hold
);
  logic [3:0] hi_q;

  assign byte_done = cap_en && !cap_hi;
  assign hold      = m_valid && !m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (cap_en && cap_hi) hi_q <= io_in;
      if (byte_done) begin
        m_data  <= join_nibbles(hi_q, io_in);
        m_valid <= 1'b1;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qrd_ctrl.sv
module qrd_ctrl
  import qrd_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               addr4,
  input  logic [LEN_W-1:0]   byte_count,
  input  logic [DUMMY_W-1:0] dummy_cycles,
  input  logic               quad_en,
  input  logic               tick,
  input  logic               hold,
  output phase_t             phase,
  output logic               sck,
  output logic               cs_n,
  output logic               busy,
  output logic               accept,
  output logic               run,
  output logic               rise_evt,
  output logic               fall_evt,
  output logic               shift_en,
  output logic               cap_en,
  output logic               cap_hi
);
  localparam int CW0 = (LEN_W + 1 > DUMMY_W) ? LEN_W + 1 : DUMMY_W;
  localparam int CW  = (CW0 > 6) ? CW0 : 6;

  logic [CW-1:0]      left;
  logic [DUMMY_W-1:0] dummy_q;
  logic [LEN_W-1:0]   count_q;
  logic               guard_half;
  logic               stall_now;
  logic               adv;
  logic               active;

  assign accept    = start && (phase == PH_IDLE) && quad_en && (byte_count != '0);
  assign run       = (phase != PH_IDLE);
  assign busy      = run;
  assign active    = (phase == PH_SEND) || (phase == PH_DUMMY) || (phase == PH_DATA);
  // pause before the rising edge that would finish a byte while the output is full
  assign stall_now = hold && (phase == PH_DATA) && !sck && left[0];
  assign adv       = tick && !stall_now;
  assign rise_evt  = adv && !sck && active;
  assign fall_evt  = adv && sck;
  assign shift_en  = fall_evt && (phase == PH_SEND) && (left != '0);
  assign cap_en    = rise_evt && (phase == PH_DATA);
  assign cap_hi    = !left[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sck        <= 1'b0;
      cs_n       <= 1'b1;
      left       <= '0;
      dummy_q    <= '0;
      count_q    <= '0;
      guard_half <= 1'b0;
    end else if (accept) begin
      phase   <= PH_SEND;
      cs_n    <= 1'b0;
      sck     <= 1'b0;
      left    <= CW'(frame_bits(addr4));
      dummy_q <= dummy_cycles;
      count_q <= byte_count;
    end else if (rise_evt) begin
      sck  <= 1'b1;
      left <= left - 1'b1;
    end else if (fall_evt) begin
      sck <= 1'b0;
      if (left == '0) begin
        case (phase)
          PH_SEND: begin
            if (dummy_q != '0) begin
              phase <= PH_DUMMY;
              left  <= CW'(dummy_q);
            end else begin
              phase <= PH_DATA;
              left  <= CW'({count_q, 1'b0});
            end
          end
          PH_DUMMY: begin
            phase <= PH_DATA;
            left  <= CW'({count_q, 1'b0});
          end
          PH_DATA: begin
            phase      <= PH_GUARD;
            cs_n       <= 1'b1;
            guard_half <= 1'b0;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end else if (adv && (phase == PH_GUARD)) begin
      if (guard_half) phase <= PH_IDLE;
      guard_half <= 1'b1;
    end
  end
endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader
  import qrd_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 16,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               quad_en,
  input  logic               start,
  input  logic               addr4,
  input  logic [31:0]        start_addr,
  input  logic [LEN_W-1:0]   byte_count,
  input  logic [DUMMY_W-1:0] dummy_cycles,
  output logic               busy,
  output logic               sck,
  output logic               cs_n,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in,
  output logic               m_valid,
  output logic [7:0]         m_data,
  input  logic               m_ready
);
  phase_t phase;
  logic   tick, run, accept, hold;
  logic   rise_evt, fall_evt, shift_en, cap_en, cap_hi, byte_done;
  logic   io0;

  qrd_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(accept), .tick(tick)
  );

  qrd_ctrl #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .addr4(addr4),
    .byte_count(byte_count), .dummy_cycles(dummy_cycles), .quad_en(quad_en),
    .tick(tick), .hold(hold), .phase(phase), .sck(sck), .cs_n(cs_n),
    .busy(busy), .accept(accept), .run(run), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .shift_en(shift_en), .cap_en(cap_en), .cap_hi(cap_hi)
  );

  qrd_txshift u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .addr(start_addr),
    .addr4(addr4), .shift(shift_en), .io0(io0)
  );

  qrd_rxpack u_rx (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_hi(cap_hi),
    .io_in(io_in), .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .byte_done(byte_done), .hold(hold)
  );

  assign io_out = {3'b000, io0};
  assign io_oe  = {3'b000, (phase == PH_SEND)};
endmodule

// File: rtl/qrd_checker.sv
module qrd_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             quad_en,
  input logic [LEN_W-1:0] byte_count,
  input logic             busy,
  input logic             cs_n,
  input logic             sck,
  input logic [3:0]       io_oe,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             rise_evt,
  input logic             fall_evt
);
  assert_upper_lanes_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe[3:1] == 3'b000);

  assert_drive_only_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe[0] |-> !cs_n);

  assert_sck_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_sck_moves_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt && !fall_evt) |=> $stable(sck));

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_refuse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (!quad_en || byte_count == '0)) |=> (!busy && cs_n));

  assert_busy_covers_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_busy_ends_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cs_n);
endmodule

bind qspi_quad_reader qrd_checker #(.LEN_W(LEN_W)) u_qrd_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .quad_en(quad_en),
  .byte_count(byte_count), .busy(busy), .cs_n(cs_n), .sck(sck),
  .io_oe(io_oe), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .rise_evt(rise_evt), .fall_evt(fall_evt)
);

// File: tb/qspi_quad_reader_test.sv
module qspi_quad_reader_test;
  localparam int CLK_DIV = 2;
  localparam int LEN_W   = 8;
  localparam int DUMMY_W = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               quad_en = 1'b1;
  logic               start = 1'b0;
  logic               addr4 = 1'b0;
  logic [31:0]        start_addr = '0;
  logic [LEN_W-1:0]   byte_count = '0;
  logic [DUMMY_W-1:0] dummy_cycles = '0;
  logic               busy, sck, cs_n, m_valid;
  logic [3:0]         io_out, io_oe;
  logic [3:0]         io_in = 4'h0;
  logic [7:0]         m_data;
  logic               m_ready = 1'b1;

  always #2 clk = ~clk;

  qspi_quad_reader #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) uut (
    .clk(clk), .rst_n(rst_n), .quad_en(quad_en), .start(start), .addr4(addr4),
    .start_addr(start_addr), .byte_count(byte_count), .dummy_cycles(dummy_cycles),
    .busy(busy), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  int vectors = 0;
  int errors  = 0;

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  // behavioural flash responder
  int          rc = 0;
  logic [39:0] rxb = '0;
  bit          cur_a4 = 1'b0;
  int          cur_d = 0;
  int          oe_err = 0;

  always @(negedge cs_n) begin
    rc  = 0;
    rxb = '0;
  end

  always @(posedge sck) begin
    if (rc < (cur_a4 ? 40 : 32)) begin
      rxb = {rxb[38:0], io_out[0]};
      if (!io_oe[0]) oe_err++;
    end else if (io_oe[0]) begin
      oe_err++;
    end
    rc++;
  end

  always @(negedge sck) begin
    int          j;
    logic [31:0] fa;
    logic [31:0] msk;
    logic [7:0]  b;
    j   = rc - ((cur_a4 ? 40 : 32) + cur_d);
    msk = cur_a4 ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
    fa  = cur_a4 ? rxb[31:0] : {8'h00, rxb[23:0]};
    if (j >= 0) begin
      b     = pat((fa + 32'(j / 2)) & msk);
      io_in = (j % 2 == 0) ? b[7:4] : b[3:0];
    end else begin
      io_in = 4'h9;
    end
  end

  // consumer and monitors, sampled on the falling system clock edge
  logic [7:0] rx_q[$];
  int         rmode = 0;
  int         rcyc = 0;
  int         stall_err = 0;
  int         guard_err = 0;
  int         hi_cnt = 1000;
  bit         last_cs = 1'b1;
  bit         hold_prev = 1'b0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    if (hold_prev && !(m_valid && m_data == prev_data)) stall_err++;
    rcyc++;
    case (rmode)
      1:       m_ready = (rcyc % 13 == 0);
      2:       m_ready = (rcyc % 29 == 0);
      default: m_ready = 1'b1;
    endcase
    if (m_valid && m_ready) rx_q.push_back(m_data);
    hold_prev = m_valid && !m_ready;
    prev_data = m_data;
    if (io_oe[3:1] != 3'b000) oe_err++;
    if (cs_n) hi_cnt++;
    else begin
      if (last_cs && hi_cnt < 2 * CLK_DIV) guard_err++;
      hi_cnt = 0;
    end
    last_cs = cs_n;
  end

  task automatic run(input logic [31:0] a, input bit a4, input int d, input int n,
                     input int rm, input bit poke);
    logic [31:0] msk;
    logic [7:0]  f_op;
    logic [31:0] f_addr;
    int          waitc;
    msk = a4 ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
    rx_q.delete();
    oe_err = 0; stall_err = 0; guard_err = 0;
    rmode = rm; cur_a4 = a4; cur_d = d;
    @(negedge clk);
    start_addr = a; addr4 = a4; dummy_cycles = DUMMY_W'(d); byte_count = LEN_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after accepted start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (10) @(negedge clk);
      start_addr = ~a; addr4 = ~a4; start = 1'b1;
      @(negedge clk);
      start = 1'b0; start_addr = a; addr4 = a4;
    end
    while (busy) @(negedge clk);
    check(cs_n && !sck, "R6 deselected with sck low", 64'({cs_n, sck}), 64'h2);
    waitc = 0;
    while (rx_q.size() < n && waitc < 600) begin
      @(negedge clk);
      waitc++;
    end
    f_op   = a4 ? rxb[39:32] : rxb[31:24];
    f_addr = a4 ? rxb[31:0] : {8'h00, rxb[23:0]};
    check(f_op == (a4 ? 8'h6C : 8'h6B), "R1 instruction code", 64'(f_op),
          64'(a4 ? 8'h6C : 8'h6B));
    check(f_addr == (a & msk), "R2 address bits", 64'(f_addr), 64'(a & msk));
    check(rc == (a4 ? 40 : 32) + d + 2 * n, "R4 rising edge total", 64'(rc),
          64'((a4 ? 40 : 32) + d + 2 * n));
    check(rx_q.size() == n, "R6 byte count", 64'(rx_q.size()), 64'(n));
    for (int k = 0; k < n; k++) begin
      if (k < rx_q.size())
        check(rx_q[k] == pat((a + 32'(k)) & msk), "R5 byte nibble order",
              64'(rx_q[k]), 64'(pat((a + 32'(k)) & msk)));
    end
    check(oe_err == 0, "R3 lane drive", 64'(oe_err), 64'd0);
    check(stall_err == 0, "R7 stream hold", 64'(stall_err), 64'd0);
    check(guard_err == 0, "R9 chip select recovery", 64'(guard_err), 64'd0);
  endtask

  task automatic refuse(input bit q, input int n);
    @(negedge clk);
    quad_en = q; byte_count = LEN_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(!busy && cs_n, "R8 start refused", 64'({busy, cs_n}), 64'h1);
    quad_en = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    vectors++;
    errors++;
    $display("FAIL R6 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int dl[5];
    int nl[3];
    int idx;
    logic [31:0] a;
    dl[0] = 0; dl[1] = 1; dl[2] = 2; dl[3] = 8; dl[4] = 15;
    nl[0] = 1; nl[1] = 2; nl[2] = 5;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && m_valid == 1'b0 && io_oe == 4'h0,
          "R10 reset state", 64'({cs_n, sck, busy, m_valid, io_oe}), 64'h80);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    refuse(1'b0, 3);
    refuse(1'b1, 0);
    idx = 0;
    for (int w = 0; w < 2; w++) begin
      for (int di = 0; di < 5; di++) begin
        for (int ni = 0; ni < 3; ni++) begin
          if (idx % 3 == 0) a = (w == 1) ? 32'hFFFF_FFFE : 32'h00FF_FFFE;
          else              a = 32'(idx) * 32'h0103_0507 + 32'd11;
          run(a, w[0], dl[di], nl[ni], idx % 3, idx == 4 || idx == 19);
          idx++;
        end
      end
    end
    refuse(1'b0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule